// File: doc/BRIEF.md
# Serial Memory Slave Protocol Engine

This block is the two-wire slave front end of a 2 KB serial memory. It watches oversampled copies of the serial clock and data lines and drives a single open-drain pull-down for the data line. After a start condition it takes in a select byte. The upper nibble must carry the fixed type code, and the next three bits give the upper part of an 11-bit memory address. For writes it then takes a byte address and any number of data bytes. Received data bytes are held in a one-row buffer of 16 bytes and are committed to a small synchronous RAM only after the stop condition. The RAM stands in for the nonvolatile array.

Reads return data from the current pointer, which advances after every byte sent. The master's acknowledge keeps the read going, and its not-acknowledge ends it. A write-lock input makes the block refuse data bytes when it is high at any moment between the start condition and the last bit of the byte address. While a commit is running, the bus is ignored completely.

Top module: `ser_eeprom_slave`

## Requirements
- R1: After reset the data pull-down is released. A start condition (data falling while clock is high) followed by a select byte whose bits 7:4 are 1010 is acknowledged by pulling data low for the ninth clock. Bits 3:1 of the select byte are the block number, and bit 0 is the direction (1 read, 0 write).
- R2: A select byte whose bits 7:4 differ from 1010 is not acknowledged. Every byte clocked after it is also ignored until the next start condition.
- R3: In a write, the byte address after the select byte is acknowledged, and so is each data byte. Data byte k lands at memory address {block, address[7:4], (address[3:0]+k) mod 16}.
- R4: If the write-lock input is high at any clock from the start condition until the eighth address bit, no data byte of that transfer is acknowledged and memory keeps its contents.
- R5: A stop condition ending a write that holds accepted data starts a write cycle lasting 16 + WR_HOLD clocks. Memory is written only inside that cycle, and during it the bus is ignored, so a select byte gets no acknowledge.
- R6: A read select byte returns data from the pointer, whose upper bits are replaced by the block number. A write select byte followed by a byte address and a repeated start therefore gives a random read. A read select byte alone reads from where the last read stopped.
- R7: During a read the pointer advances by one after each byte, across 11 bits. An acknowledge from the master causes the next byte to be sent, and a not-acknowledge releases the data line.
- R8: In a write, more than one byte per 16-byte row wraps within the row. A later byte to the same location overwrites an earlier one in the same transfer.
- R9: The block changes its data pull-down only while the clock line is low.
- R10: A stop condition after a read releases the data line, leaves the block idle with no write cycle, and a select byte that follows right away is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pin |
| sda_in | input | 1 | Serial data line as seen at the pin (resolved bus value) |
| wr_lock | input | 1 | Write lock; high refuses the data bytes of the current write |
| sda_pull | output | 1 | 1 drives the open-drain data line low |

## Verification
The hardest conditions to reach are the ones that depend on timing across transfers. One is a select byte arriving while a commit is still running. The bench issues a stop and then starts a new transfer at once, with the hold time shortened so the probe lands inside the cycle. Another is a lock pulse that covers only part of the window. The bench raises the lock once for the start condition alone and once for the address byte alone. A third is row wrap with overwrite: a 17-byte write makes the last byte land on the first location again. The bench then reads each of these back through random and current-address reads, compared against a behavioural memory model.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_ADDR,
    S_WDAT,
    S_RDAT,
    S_BUSY
  } sem_state_t;

  localparam logic [3:0] TYPE_CODE = 4'b1010;
endpackage

// File: rtl/sem_line_sync.sv
module sem_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int NL = 2;

  logic [NL-1:0] pin_w;
  logic [NL-1:0] sync_w;
  logic [NL-1:0] prev_q;

  assign pin_w = {sda_in, scl_in};

  for (genvar l = 0; l < NL; l++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], pin_w[l]};
    end
    assign sync_w[l] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= sync_w;
  end

  assign scl_s    = sync_w[0];
  assign sda_s    = sync_w[1];
  assign scl_rise = sync_w[0] & ~prev_q[0];
  assign scl_fall = ~sync_w[0] & prev_q[0];
  assign start_ev = sync_w[0] & prev_q[0] & prev_q[1] & ~sync_w[1];
  assign stop_ev  = sync_w[0] & prev_q[0] & ~prev_q[1] & sync_w[1];
endmodule

// File: rtl/sem_row_buf.sv
module sem_row_buf #(
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic          rd_valid,
  output logic          any_valid
);
  localparam int DEPTH = 1 << IW;

  logic [7:0]       data_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld_q <= '0;
    else if (clr)   vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  assign rd_data   = data_q[rd_idx];
  assign rd_valid  = vld_q[rd_idx];
  assign any_valid = |vld_q;
endmodule

// File: rtl/sem_ram.sv
module sem_ram #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int WORDS = 1 << AW;

  logic [7:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
    rdata <= mem_q[raddr];
  end
endmodule

// File: rtl/sem_proto.sv
module sem_proto
  import sem_pkg::*;
#(
  parameter int BLK_W   = 3,
  parameter int ROW_AW  = 4,
  parameter int WR_HOLD = 1000,
  localparam int AW     = 8 + BLK_W,
  localparam int RW     = AW - ROW_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_s,
  input  logic              wr_lock,
  input  logic [7:0]        rdata,
  input  logic [7:0]        buf_rd_data,
  input  logic              buf_rd_valid,
  input  logic              buf_any,
  output logic              sda_pull,
  output logic              busy,
  output logic [AW-1:0]     raddr,
  output logic              buf_clr,
  output logic              buf_we,
  output logic [ROW_AW-1:0] buf_wr_idx,
  output logic [7:0]        buf_wr_data,
  output logic [ROW_AW-1:0] buf_rd_idx,
  output logic              ram_we,
  output logic [AW-1:0]     ram_waddr,
  output logic [7:0]        ram_wdata
);
  localparam int ROW_I  = 1 << ROW_AW;
  localparam int DONE_I = ROW_I + WR_HOLD;
  localparam int CW     = $clog2(DONE_I + 1);
  localparam logic [CW-1:0] ROW_C  = CW'(ROW_I);
  localparam logic [CW-1:0] DONE_C = CW'(DONE_I);

  sem_state_t        state_q, state_n;
  logic [3:0]        cnt_q, cnt_n;
  logic              ack_q, ack_n;
  logic [7:0]        sh_q, sh_n;
  logic [6:0]        tx_q, tx_n;
  logic              pull_q, pull_n;
  logic [AW-1:0]     ptr_q, ptr_n;
  logic              lock_q, lock_n;
  logic              mack_q, mack_n;
  logic [ROW_AW-1:0] wp_q, wp_n;
  logic [RW-1:0]     row_q, row_n;
  logic [CW-1:0]     ccnt_q, ccnt_n;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    ack_n   = ack_q;
    sh_n    = sh_q;
    tx_n    = tx_q;
    pull_n  = pull_q;
    ptr_n   = ptr_q;
    lock_n  = lock_q;
    mack_n  = mack_q;
    wp_n    = wp_q;
    row_n   = row_q;
    ccnt_n  = ccnt_q;
    buf_clr = 1'b0;
    buf_we  = 1'b0;
    ram_we  = 1'b0;

    if (state_q == S_BUSY) begin
      ram_we = (ccnt_q < ROW_C) && buf_rd_valid;
      if (ccnt_q == DONE_C) state_n = S_IDLE;
      else                  ccnt_n  = ccnt_q + 1'b1;
    end else if (start_ev) begin
      state_n = S_DEV;
      cnt_n   = '0;
      ack_n   = 1'b0;
      pull_n  = 1'b0;
      lock_n  = wr_lock;
      buf_clr = 1'b1;
    end else if (stop_ev) begin
      pull_n = 1'b0;
      ack_n  = 1'b0;
      if (state_q == S_WDAT && buf_any) begin
        state_n = S_BUSY;
        ccnt_n  = '0;
      end else begin
        state_n = S_IDLE;
      end
    end else begin
      if (state_q == S_DEV || (state_q == S_ADDR && cnt_q != 4'd8))
        lock_n = lock_q | wr_lock;
      case (state_q)
        S_DEV, S_ADDR, S_WDAT: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_n  = {sh_q[6:0], sda_s};
            cnt_n = cnt_q + 1'b1;
          end
          if (scl_fall && cnt_q == 4'd8) begin
            if (!ack_q) begin
              ack_n = 1'b1;
              if (state_q == S_DEV) begin
                if (sh_q[7:4] == TYPE_CODE) begin
                  pull_n = 1'b1;
                  ptr_n  = {sh_q[BLK_W:1], ptr_q[7:0]};
                end else begin
                  state_n = S_IDLE;
                  ack_n   = 1'b0;
                  cnt_n   = '0;
                end
              end else if (state_q == S_ADDR) begin
                pull_n = 1'b1;
                ptr_n  = {ptr_q[AW-1:8], sh_q};
                wp_n   = sh_q[ROW_AW-1:0];
                row_n  = {ptr_q[AW-1:8], sh_q[7:ROW_AW]};
              end else if (!lock_q) begin
                pull_n = 1'b1;
                buf_we = 1'b1;
                wp_n   = wp_q + 1'b1;
              end
            end else begin
              ack_n  = 1'b0;
              cnt_n  = '0;
              pull_n = 1'b0;
              if (state_q == S_DEV) begin
                if (sh_q[0]) begin
                  state_n = S_RDAT;
                  tx_n    = rdata[6:0];
                  pull_n  = ~rdata[7];
                end else begin
                  state_n = S_ADDR;
                end
              end else if (state_q == S_ADDR) begin
                state_n = S_WDAT;
              end
            end
          end
        end
        S_RDAT: begin
          if (scl_rise) begin
            if (cnt_q != 4'd8) cnt_n  = cnt_q + 1'b1;
            else if (ack_q)    mack_n = ~sda_s;
          end
          if (scl_fall) begin
            if (cnt_q != 4'd8) begin
              pull_n = ~tx_q[6];
              tx_n   = {tx_q[5:0], 1'b0};
            end else if (!ack_q) begin
              ack_n  = 1'b1;
              pull_n = 1'b0;
              ptr_n  = ptr_q + 1'b1;
            end else begin
              ack_n = 1'b0;
              if (mack_q) begin
                cnt_n  = '0;
                tx_n   = rdata[6:0];
                pull_n = ~rdata[7];
              end else begin
                state_n = S_IDLE;
                pull_n  = 1'b0;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      sh_q    <= '0;
      tx_q    <= '0;
      pull_q  <= 1'b0;
      ptr_q   <= '0;
      lock_q  <= 1'b0;
      mack_q  <= 1'b0;
      wp_q    <= '0;
      row_q   <= '0;
      ccnt_q  <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      ack_q   <= ack_n;
      sh_q    <= sh_n;
      tx_q    <= tx_n;
      pull_q  <= pull_n;
      ptr_q   <= ptr_n;
      lock_q  <= lock_n;
      mack_q  <= mack_n;
      wp_q    <= wp_n;
      row_q   <= row_n;
      ccnt_q  <= ccnt_n;
    end
  end

  assign sda_pull    = pull_q;
  assign busy        = (state_q == S_BUSY);
  assign raddr       = ptr_q;
  assign buf_wr_idx  = wp_q;
  assign buf_wr_data = sh_q;
  assign buf_rd_idx  = ccnt_q[ROW_AW-1:0];
  assign ram_waddr   = {row_q, ccnt_q[ROW_AW-1:0]};
  assign ram_wdata   = buf_rd_data;
endmodule

// File: rtl/ser_eeprom_slave.sv
module ser_eeprom_slave #(
  parameter int BLK_W       = 3,
  parameter int ROW_AW      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int WR_HOLD     = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic wr_lock,
  output logic sda_pull
);
  localparam int AW = 8 + BLK_W;

  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic              busy;
  logic [AW-1:0]     raddr, ram_waddr;
  logic [7:0]        rdata, ram_wdata, buf_rd_data, buf_wr_data;
  logic              ram_we, buf_clr, buf_we, buf_rd_valid, buf_any;
  logic [ROW_AW-1:0] buf_wr_idx, buf_rd_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  sem_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_ni),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  sem_proto #(.BLK_W(BLK_W), .ROW_AW(ROW_AW), .WR_HOLD(WR_HOLD)) u_proto (
    .clk          (clk),
    .rst_n        (rst_ni),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_ev     (start_ev),
    .stop_ev      (stop_ev),
    .sda_s        (sda_s),
    .wr_lock      (wr_lock),
    .rdata        (rdata),
    .buf_rd_data  (buf_rd_data),
    .buf_rd_valid (buf_rd_valid),
    .buf_any      (buf_any),
    .sda_pull     (sda_pull),
    .busy         (busy),
    .raddr        (raddr),
    .buf_clr      (buf_clr),
    .buf_we       (buf_we),
    .buf_wr_idx   (buf_wr_idx),
    .buf_wr_data  (buf_wr_data),
    .buf_rd_idx   (buf_rd_idx),
    .ram_we       (ram_we),
    .ram_waddr    (ram_waddr),
    .ram_wdata    (ram_wdata)
  );

  sem_row_buf #(.IW(ROW_AW)) u_rowbuf (
    .clk       (clk),
    .rst_n     (rst_ni),
    .clr       (buf_clr),
    .wr_en     (buf_we),
    .wr_idx    (buf_wr_idx),
    .wr_data   (buf_wr_data),
    .rd_idx    (buf_rd_idx),
    .rd_data   (buf_rd_data),
    .rd_valid  (buf_rd_valid),
    .any_valid (buf_any)
  );

  sem_ram #(.AW(AW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (raddr),
    .rdata (rdata)
  );
endmodule

// File: rtl/sem_checker.sv
module sem_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic start_ev,
  input logic stop_ev,
  input logic sda_pull,
  input logic busy,
  input logic ram_we
);
  assert_release_on_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && !busy) |=> !sda_pull);

  assert_silent_in_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull);

  assert_write_in_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> busy);

  assert_cycle_follows_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ev));

  assert_pull_moves_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !$past(scl_s));

  assert_release_on_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && !busy) |=> !sda_pull);
endmodule

bind ser_eeprom_slave sem_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_ni),
  .scl_s    (scl_s),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .sda_pull (sda_pull),
  .busy     (busy),
  .ram_we   (ram_we)
);

// File: tb/tb_ser_eeprom_slave.sv
module tb_ser_eeprom_slave;
  localparam int HALF = 20;
  localparam int HOLD = 600;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, m_scl, m_sda, wr_lock;
  wire  sda_pull;
  wire  sda_line = m_sda & ~sda_pull;

  ser_eeprom_slave #(.WR_HOLD(HOLD)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (m_scl),
    .sda_in   (sda_line),
    .wr_lock  (wr_lock),
    .sda_pull (sda_pull)
  );

  int total = 0;
  int bad = 0;
  int model [2048];
  int mptr = 0;
  int viol = 0;
  int interf = 0;
  logic prev_pull = 1'b0;
  logic [7:0] pay[$];

  // every-clock monitor: pull-down may only move while the clock line is low (R9)
  always @(negedge clk) begin
    if (rst_n && (sda_pull !== prev_pull) && m_scl) viol++;
    prev_pull = sda_pull;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic got);
    w(HALF/2); m_sda = b;
    w(HALF/2); m_scl = 1'b1;
    w(HALF/2); got = sda_line;
    w(HALF/2); m_scl = 1'b0;
  endtask

  task automatic do_start();
    w(HALF/2); m_sda = 1'b1;
    w(HALF/2); m_scl = 1'b1;
    w(HALF/2); m_sda = 1'b0;
    w(HALF/2); m_scl = 1'b0;
  endtask

  task automatic do_stop();
    w(HALF/2); m_sda = 1'b0;
    w(HALF/2); m_scl = 1'b1;
    w(HALF/2); m_sda = 1'b1;
    w(HALF/2);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic g;
    for (int i = 7; i >= 0; i--) begin
      bit_io(v[i], g);
      if (g !== v[i]) interf++;
    end
    bit_io(1'b1, g);
    acked = (g === 1'b0);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] v);
    logic g;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, g);
      v[i] = g;
    end
    bit_io(~give_ack, g);
  endtask

  // lock_mode: 0 none, 1 high only around the start, 2 high only during the address byte
  task automatic write_seq(input int blk, input int addr, input int lock_mode,
                           input logic exp_ack, input string req);
    logic a;
    if (lock_mode == 1) wr_lock = 1'b1;
    do_start();
    wr_lock = 1'b0;
    send_byte({4'b1010, 3'(blk), 1'b0}, a); chk({req, " select ack"}, a, 1);
    if (lock_mode == 2) wr_lock = 1'b1;
    send_byte(8'(addr), a);                 chk({req, " address ack"}, a, 1);
    wr_lock = 1'b0;
    foreach (pay[k]) begin
      send_byte(pay[k], a);
      chk({req, " data ack"}, a, exp_ack);
    end
    do_stop();
    if (exp_ack)
      foreach (pay[k])
        model[blk*256 + (addr & 'hF0) + ((addr + k) & 'hF)] = int'(pay[k]);
  endtask

  task automatic read_body(input int n, input string req);
    logic [7:0] v;
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n-1, v);
      chk({req, " read data"}, v, model[mptr] & 'hFF);
      mptr = (mptr + 1) % 2048;
    end
    w(HALF/2);
    chk("R7 release after not-acknowledge", sda_pull, 0);
    do_stop();
  endtask

  task automatic read_rand(input int blk, input int addr, input int n, input string req);
    logic a;
    do_start();
    send_byte({4'b1010, 3'(blk), 1'b0}, a); chk({req, " select ack"}, a, 1);
    send_byte(8'(addr), a);                 chk({req, " address ack"}, a, 1);
    do_start();
    send_byte({4'b1010, 3'(blk), 1'b1}, a); chk({req, " read select ack"}, a, 1);
    mptr = blk*256 + addr;
    read_body(n, req);
  endtask

  task automatic read_cur(input int blk, input int n, input string req);
    logic a;
    do_start();
    send_byte({4'b1010, 3'(blk), 1'b1}, a); chk({req, " read select ack"}, a, 1);
    mptr = blk*256 + (mptr & 'hFF);
    read_body(n, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic a;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; wr_lock = 1'b0;
    w(10);
    chk("R1 reset release", sda_pull, 0);
    rst_n = 1'b1;
    w(10);

    // R3: write four bytes into block 3
    pay.delete();
    pay.push_back(8'h11); pay.push_back(8'h22); pay.push_back(8'h33); pay.push_back(8'h44);
    write_seq(3, 'h10, 0, 1'b1, "R3");

    // R5: select during the write cycle is ignored
    do_start();
    send_byte(8'hA6, a); chk("R5 no ack while busy", a, 0);
    do_stop();
    w(HOLD + 200);

    // R6/R7: random read of three bytes, then a current-address read (R10 right after a stop)
    read_rand(3, 'h10, 3, "R6");
    read_cur(3, 1, "R10");

    // R2: wrong type code, following byte ignored as well
    do_start();
    send_byte(8'h60, a); chk("R2 wrong code no ack", a, 0);
    send_byte(8'hA0, a); chk("R2 ignored until start", a, 0);
    do_stop();

    // R4: lock at the start only, then during the address only
    pay.delete(); pay.push_back(8'h99);
    write_seq(3, 'h11, 1, 1'b0, "R4");
    w(HOLD + 200);
    pay.delete(); pay.push_back(8'h77);
    write_seq(3, 'h12, 2, 1'b0, "R4");
    w(HOLD + 200);
    read_rand(3, 'h11, 2, "R4");

    // R8: wrap inside a row, and a 17-byte write that overwrites its first slot
    pay.delete();
    for (int k = 0; k < 5; k++) pay.push_back(8'hA1 + 8'(k));
    write_seq(5, 'h3E, 0, 1'b1, "R8");
    w(HOLD + 200);
    pay.delete();
    for (int k = 0; k < 17; k++) pay.push_back(8'h50 + 8'(k));
    write_seq(5, 'h40, 0, 1'b1, "R8");
    w(HOLD + 200);
    read_rand(5, 'h30, 3, "R8");
    read_rand(5, 'h3E, 4, "R7");
    read_cur(5, 2, "R7");

    chk("R9 no drive change while clock high", viol, 0);
    chk("R9 no interference with master bits", interf, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule